// File: doc/BRIEF.md
# Prioritized Interrupt ID Resolver

The resolver looks at three pending words, a basic word and two 32-bit bank words, and names the single interrupt that should be serviced next. The answer is a 7-bit identifier that packs a 2-bit bank number above a 5-bit source number, plus a valid flag. An error flag is also provided. All three outputs are registered, so the answer for the inputs presented before a clock edge appears just after that edge.

The basic word carries three kinds of bits:
- eight direct sources in bits 0-7;
- summary bits 8 and 9, which point into bank 1 and bank 2;
- shortcut bits 10-20, which stand for particular bank 1 and bank 2 sources.

A shortcut is reported under the bank and source number it stands for, and it outranks the summary bits. When a summary bit wins, the source number comes from the lowest set bit of that bank's own word. Bits above 20 of the basic word are ignored.

A summary bit can win while its bank word holds nothing. In that case the resolver raises an error instead of inventing a source.

Top module: `irq_id_resolver`

## Requirements
- R1: The identifier is 7 bits: bits 6:5 hold the bank (0 basic, 1 bank 1, 2 bank 2) and bits 4:0 hold the source number within that bank.
- R2: Basic word bits 21-31 are ignored. A basic word with only those bits set yields no interrupt, whatever the bank words hold.
- R3: When nothing qualifies, id_o is 7'h7F, valid_o is 0 and err_o is 0.
- R4: Groups are ranked from highest to lowest as follows:
  - basic bits 0-7;
  - bank 1 shortcuts (basic bits 10-14);
  - bank 2 shortcuts (basic bits 15-20);
  - bank 1 summary (basic bit 8);
  - bank 2 summary (basic bit 9).
- R5: Within a group, the lowest-numbered set bit wins. A win in basic bits 0-7 reports bank 0 and that bit number.
- R6: The shortcuts translate as follows:
  - basic bits 10, 11, 12, 13 and 14 give bank 1 sources 7, 9, 10, 18 and 19;
  - basic bits 15, 16, 17, 18, 19 and 20 give bank 2 sources 21, 22, 23, 24, 25 and 30.
- R7: When a summary bit wins, the source number is the lowest set bit of that bank's pending word.
- R8: When a summary bit wins and its bank word is zero, err_o is 1, valid_o is 0 and id_o is 7'h7F. A lower-ranked group is not consulted.
- R9: Outputs are registered with one cycle of latency. While rst_ni is low, id_o is 7'h7F, valid_o is 0 and err_o is 0.
- R10: A bank word has no effect unless its summary bit is the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| basic_i | input | 32 | Basic pending word |
| bank1_i | input | 32 | Bank 1 pending word |
| bank2_i | input | 32 | Bank 2 pending word |
| id_o | output | 7 | Registered identifier, {bank, source} |
| valid_o | output | 1 | Registered: an interrupt was found |
| err_o | output | 1 | Registered: winning summary bit with an empty bank word |

## Verification
The hardest situation to reach is a pattern where a higher group hides a lower one, for example:
- a shortcut that must beat a set summary bit whose bank word is also populated;
- a bank 1 summary with an empty word that must raise an error even though bank 2 holds a valid source.

The vector table builds these masking patterns on purpose, pairing each winner with a live loser in the next group. Further vectors place every shortcut bit at its table edges and set the ignored high basic bits together with full bank words.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int WORD_W     = 32;
  localparam int BANK_W     = 2;
  localparam int SRC_W      = 5;
  localparam int ID_W       = BANK_W + SRC_W;
  localparam int DIRECT_N   = 8;
  localparam int SUM1_BIT   = DIRECT_N;
  localparam int SUM2_BIT   = DIRECT_N + 1;
  localparam int SC1_LO     = DIRECT_N + 2;
  localparam int SC1_N      = 5;
  localparam int SC2_LO     = SC1_LO + SC1_N;
  localparam int SC2_N      = 6;
  localparam int VALID_TOP  = SC2_LO + SC2_N - 1;
  localparam logic [ID_W-1:0] NONE_ID = '1;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [SRC_W-1:0]  src_t;

  // shortcut position -> true source in bank 1
  function automatic src_t sc1_src(input logic [2:0] idx);
    case (idx)
      3'd0:    return src_t'(7);
      3'd1:    return src_t'(9);
      3'd2:    return src_t'(10);
      3'd3:    return src_t'(18);
      default: return src_t'(19);
    endcase
  endfunction

  // shortcut position -> true source in bank 2
  function automatic src_t sc2_src(input logic [2:0] idx);
    case (idx)
      3'd0:    return src_t'(21);
      3'd1:    return src_t'(22);
      3'd2:    return src_t'(23);
      3'd3:    return src_t'(24);
      3'd4:    return src_t'(25);
      default: return src_t'(30);
    endcase
  endfunction
endpackage

// File: rtl/lsb_finder.sv
module lsb_finder #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/id_select.sv
module id_select
  import irq_res_pkg::*;
(
  input  logic            dir_found_i,
  input  logic [2:0]      dir_idx_i,
  input  logic            sc1_found_i,
  input  logic [2:0]      sc1_idx_i,
  input  logic            sc2_found_i,
  input  logic [2:0]      sc2_idx_i,
  input  logic            sum1_i,
  input  logic            sum2_i,
  input  logic            b1_found_i,
  input  logic [SRC_W-1:0] b1_idx_i,
  input  logic            b2_found_i,
  input  logic [SRC_W-1:0] b2_idx_i,
  output logic [ID_W-1:0] id_o,
  output logic            valid_o,
  output logic            err_o
);
  always_comb begin
    id_o    = NONE_ID;
    valid_o = 1'b0;
    err_o   = 1'b0;
    if (dir_found_i) begin
      id_o    = {bank_t'(0), src_t'(dir_idx_i)};
      valid_o = 1'b1;
    end else if (sc1_found_i) begin
      id_o    = {bank_t'(1), sc1_src(sc1_idx_i)};
      valid_o = 1'b1;
    end else if (sc2_found_i) begin
      id_o    = {bank_t'(2), sc2_src(sc2_idx_i)};
      valid_o = 1'b1;
    end else if (sum1_i) begin
      if (b1_found_i) begin
        id_o    = {bank_t'(1), b1_idx_i};
        valid_o = 1'b1;
      end else begin
        err_o = 1'b1;
      end
    end else if (sum2_i) begin
      if (b2_found_i) begin
        id_o    = {bank_t'(2), b2_idx_i};
        valid_o = 1'b1;
      end else begin
        err_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_id_resolver.sv
module irq_id_resolver
  import irq_res_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] basic_i,
  input  logic [WORD_W-1:0] bank1_i,
  input  logic [WORD_W-1:0] bank2_i,
  output logic [ID_W-1:0]   id_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam logic [WORD_W-1:0] VALID_MASK = WORD_W'((64'd1 << (VALID_TOP + 1)) - 64'd1);

  logic [WORD_W-1:0] basic_m;
  assign basic_m = basic_i & VALID_MASK;

  logic [2:0]       dir_idx, sc1_idx, sc2_idx;
  logic [SRC_W-1:0] b1_idx, b2_idx;
  logic             dir_f, sc1_f, sc2_f, b1_f, b2_f;

  lsb_finder #(.W(DIRECT_N), .IDX_W(3)) dir_lsb_i (
    .vec_i(basic_m[DIRECT_N-1:0]), .idx_o(dir_idx), .found_o(dir_f));
  lsb_finder #(.W(SC1_N), .IDX_W(3)) sc1_lsb_i (
    .vec_i(basic_m[SC1_LO +: SC1_N]), .idx_o(sc1_idx), .found_o(sc1_f));
  lsb_finder #(.W(SC2_N), .IDX_W(3)) sc2_lsb_i (
    .vec_i(basic_m[SC2_LO +: SC2_N]), .idx_o(sc2_idx), .found_o(sc2_f));
  lsb_finder #(.W(WORD_W), .IDX_W(SRC_W)) b1_lsb_i (
    .vec_i(bank1_i), .idx_o(b1_idx), .found_o(b1_f));
  lsb_finder #(.W(WORD_W), .IDX_W(SRC_W)) b2_lsb_i (
    .vec_i(bank2_i), .idx_o(b2_idx), .found_o(b2_f));

  logic [ID_W-1:0] id_d;
  logic            valid_d, err_d;

  id_select sel_i (
    .dir_found_i(dir_f), .dir_idx_i(dir_idx),
    .sc1_found_i(sc1_f), .sc1_idx_i(sc1_idx),
    .sc2_found_i(sc2_f), .sc2_idx_i(sc2_idx),
    .sum1_i(basic_m[SUM1_BIT]), .sum2_i(basic_m[SUM2_BIT]),
    .b1_found_i(b1_f), .b1_idx_i(b1_idx),
    .b2_found_i(b2_f), .b2_idx_i(b2_idx),
    .id_o(id_d), .valid_o(valid_d), .err_o(err_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o    <= NONE_ID;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      id_o    <= id_d;
      valid_o <= valid_d;
      err_o   <= err_d;
    end
  end

  // R3
  none_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> id_o == NONE_ID);

  // R8
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o);

  // R2
  masked_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (basic_i[VALID_TOP:0] == '0) |=> (!valid_o && !err_o));

  // R4
  direct_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (basic_i[DIRECT_N-1:0] != '0) |=> (valid_o && id_o[ID_W-1:SRC_W] == '0));

  // R6
  sc1_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (basic_i[DIRECT_N-1:0] == '0 && basic_i[SC1_LO]) |=> (valid_o && id_o == ID_W'(39)));
endmodule

// File: tb/irq_id_resolver_tb_top.sv
module irq_id_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] basic = '0, bank1 = '0, bank2 = '0;
  logic [6:0]  id;
  logic        valid, err;
  int          checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  irq_id_resolver dut_i (
    .clk_i(clk), .rst_ni(rst_n), .basic_i(basic), .bank1_i(bank1),
    .bank2_i(bank2), .id_o(id), .valid_o(valid), .err_o(err));

  typedef struct packed {
    logic [7:0]  req;
    logic [31:0] b0;
    logic [31:0] b1;
    logic [31:0] b2;
    logic [6:0]  eid;
    logic        ev;
    logic        ee;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'd3,  32'h0,          32'h0,        32'h0,        7'h7F, 1'b0, 1'b0}, // R3
    '{8'd5,  32'h0000_0005,  32'h0,        32'h0,        7'd0,  1'b1, 1'b0}, // R5
    '{8'd4,  32'h0000_0480,  32'h0,        32'h0,        7'd7,  1'b1, 1'b0}, // R4 direct beats shortcut
    '{8'd6,  32'h0000_1000,  32'h0,        32'h0,        7'd42, 1'b1, 1'b0}, // R6 bank1 src10
    '{8'd4,  32'h0000_C000,  32'h0,        32'h0,        7'd51, 1'b1, 1'b0}, // R4 sc1 beats sc2
    '{8'd6,  32'h0000_8000,  32'h0,        32'h0,        7'd85, 1'b1, 1'b0}, // R6 bank2 src21
    '{8'd6,  32'h0010_0000,  32'h0,        32'h0,        7'd94, 1'b1, 1'b0}, // R6 bank2 src30
    '{8'd6,  32'h0008_0000,  32'h0,        32'h0,        7'd89, 1'b1, 1'b0}, // R6 bank2 src25
    '{8'd6,  32'h0000_2000,  32'h0,        32'h0,        7'd50, 1'b1, 1'b0}, // R6 bank1 src18
    '{8'd4,  32'h0010_0100,  32'h0000_0001,32'h0,        7'd94, 1'b1, 1'b0}, // R4 shortcut beats summary
    '{8'd7,  32'h0000_0100,  32'h8001_0000,32'h0,        7'd48, 1'b1, 1'b0}, // R7
    '{8'd1,  32'h0000_0200,  32'h0,        32'h8000_0000,7'd95, 1'b1, 1'b0}, // R1 / R7 bank2 src31
    '{8'd4,  32'h0000_0300,  32'h0000_0002,32'h0000_0001,7'd33, 1'b1, 1'b0}, // R4 sum1 beats sum2
    '{8'd2,  32'hFFE0_0000,  32'hFF,       32'hFF,       7'h7F, 1'b0, 1'b0}, // R2
    '{8'd10, 32'h0,          32'hFFFF,     32'h1,        7'h7F, 1'b0, 1'b0}, // R10
    '{8'd8,  32'h0000_0100,  32'h0,        32'h4,        7'h7F, 1'b0, 1'b1}, // R8 sum1 only
    '{8'd8,  32'h0000_0300,  32'h0,        32'h4,        7'h7F, 1'b0, 1'b1}, // R8 sum2 masked
    '{8'd10, 32'h0000_0004,  32'hFFFF_FFFF,32'hFFFF_FFFF,7'd2,  1'b1, 1'b0}  // R10 banks unused
  };

  task automatic check(input int req, input logic [6:0] eid, input logic ev, input logic ee);
    checks++;
    if (id !== eid || valid !== ev || err !== ee) begin
      failures++;
      $display("FAIL R%0d: id=%0d valid=%0b err=%0b expected id=%0d valid=%0b err=%0b",
               req, id, valid, err, eid, ev, ee);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    basic = 32'h1;
    repeat (3) @(negedge clk);
    check(9, 7'h7F, 1'b0, 1'b0);  // R9 reset state despite pending input
    rst_n = 1'b1;
    basic = '0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      basic = VECS[i].b0;
      bank1 = VECS[i].b1;
      bank2 = VECS[i].b2;
      @(negedge clk);
      check(int'(VECS[i].req), VECS[i].eid, VECS[i].ev, VECS[i].ee);
    end

    // R9 latency: old result holds until the next edge
    basic = '0; bank1 = '0; bank2 = '0;
    @(negedge clk);
    basic = 32'h0000_0400;
    #1;
    check(9, 7'h7F, 1'b0, 1'b0);
    @(negedge clk);
    check(9, 7'd39, 1'b1, 1'b0);  // R6 bank1 src7

    // R9 asynchronous reset clears a live result
    #1 rst_n = 1'b0;
    #1;
    check(9, 7'h7F, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(9, 7'd39, 1'b1, 1'b0);

    // R8 error clears once bank word fills
    basic = 32'h0000_0200; bank2 = '0;
    @(negedge clk);
    check(8, 7'h7F, 1'b0, 1'b1);
    bank2 = 32'h0000_0010;
    @(negedge clk);
    check(7, 7'd68, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule